// File: doc/BRIEF.md
# Serial Port Register File with Interrupt Logic

This block is the register file of a serial port. A host reaches it through a word-indexed read/write bus. It holds the control words, the baud divider storage and the status words. It also keeps a holding register that stores one received character. A line-side deserializer delivers received characters and line-break events as single-cycle strobes. An accepted write to the transmit index becomes a single-cycle byte strobe towards a serializer.

The block has one interrupt output, a level signal. It is built combinationally from the registered status bits, each gated by its own enable, and those enables live in control words 1 and 4. Reading the receive index consumes the held character. A write to control word 2 with its reset bit at zero returns most of the state to its reset values.

Top module: `uart_regfile`

## Requirements
- R1: After `rst_n` is low, reads return the following values:
  - index 0x00 (receive): 0x4000
  - index 0x20 (control 1): 0
  - index 0x21 (control 2): 0x0001
  - index 0x22 (control 3): 0x0700
  - index 0x23 (control 4): 0
  - index 0x24 (FIFO control): 0
  - index 0x25 (status 1): 0x6040, with transmit-ready at bit 13, receiver-idle at bit 6 and RTS-state at bit 14
  - index 0x26 (status 2): 0x4028, with transmit-FIFO-empty at bit 14, transmit-complete at bit 3 and carrier-input at bit 5
  - index 0x2A (modulator): 0
  - index 0x2B (count): 4
  - index 0x2C (one-ms): 0
  - index 0x2D (test): 0x0060, with RX-empty at bit 5 and TX-empty at bit 6
- R2: Writes to control 1–4, FIFO control, modulator and one-ms store bits 15:0 and drop the upper bits. A write to the increment index 0x29 stores into the count register 0x2B. A read of 0x29 returns 0.
- R3: A read of an index outside the defined set returns 0. A write to such an index, or to the test index 0x2D, changes no register.
- R4: A read of index 0x00 returns the held word.
  - If RX-empty (test bit 5) is clear, bit 15 of the returned value is also set.
  - That read clears status-1 bit 9 and status-2 bit 0, and sets RX-empty.
  - The held word itself is kept.
- R5: A `rx_valid` character is accepted only while status-1 bit 9 is clear. `rx_ready` shows that condition. An accepted character is stored in bits 7:0 with zero above it. It sets status-1 bit 9 and status-2 bit 0, and clears RX-empty. A character that is not accepted is dropped.
- R6: A `rx_break` strobe is taken even when a character is held.
  - It stores 0x5800 (break bit 11, framing bit 12, error bit 14).
  - It sets status-2 bit 2 and the same ready flags as a character.
  - It wins over a `rx_valid` in the same cycle.
- R7: A write to control 2 with bit 0 at zero returns the following to their R1 values: the held word, status 1, status 2, test, control 1, control 3, modulator and count. Control 4, FIFO control and one-ms keep their contents. Control 2 stores the written value with bit 0 forced to 1.
- R8: A write of ones to status 1 clears only the bits in mask 0x9DB0. A write of ones to status 2 clears only the bits in mask 0xBDD6. Every other bit ignores the write.
- R9: `irq` is high when any of these holds:
  - status-1 bit 13 and control-1 bit 13 are both set
  - status-1 bit 9 and control-1 bit 9 are both set
  - status-2 bit 14 and control-1 bit 6 are both set
  - status-2 bit 3 and control-4 bit 3 are both set
  - status-2 bit 0 and control-4 bit 0 are both set
- R10: A write to index 0x10 while control-2 bit 2 is set makes the following happen in the next cycle only:
  - `tx_valid` is high, with `tx_data` carrying write bits 7:0.
  - Status-1 bit 13 and status-2 bit 3 read low.

  With control-2 bit 2 clear, the write has no effect.
- R11: Ordering within one cycle:
  - A consuming receive read and a break strobe in the same cycle leave the break word held and ready.
  - A soft reset wins over a character or a break arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 6 | Word index of the accessed register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects at the edge) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `reg_idx`, combinational from state |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_break | input | 1 | Line break strobe |
| rx_ready | output | 1 | Holding register can take a character |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after the single-character holding behaviour.
- A design that accepted a second character while one is held would overwrite unread data.
- A design that gated break on `rx_ready` would lose the break word.

It checks the one-cycle drop of transmit-ready after a transmit write. A design that kept the flag high would keep the interrupt asserted through the transfer.

It also checks the soft reset through control 2. A design that cleared control 4, FIFO control or one-ms, or that stored bit 0 as written, shows different read-back values.

The masked write-one-to-clear on both status words is exercised with all-ones writes. A wrong mask would erase transmit-ready or FIFO-empty.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int IDX_W  = 6,
  parameter int REG_W  = 16,
  parameter int BUS_W  = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_break,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  output logic              irq
);
  localparam logic [IDX_W-1:0] IX_RXD = IDX_W'(6'h00);
  localparam logic [IDX_W-1:0] IX_TXD = IDX_W'(6'h10);
  localparam logic [IDX_W-1:0] IX_C1  = IDX_W'(6'h20);
  localparam logic [IDX_W-1:0] IX_C2  = IDX_W'(6'h21);
  localparam logic [IDX_W-1:0] IX_C3  = IDX_W'(6'h22);
  localparam logic [IDX_W-1:0] IX_C4  = IDX_W'(6'h23);
  localparam logic [IDX_W-1:0] IX_FC  = IDX_W'(6'h24);
  localparam logic [IDX_W-1:0] IX_S1  = IDX_W'(6'h25);
  localparam logic [IDX_W-1:0] IX_S2  = IDX_W'(6'h26);
  localparam logic [IDX_W-1:0] IX_INC = IDX_W'(6'h29);
  localparam logic [IDX_W-1:0] IX_MOD = IDX_W'(6'h2A);
  localparam logic [IDX_W-1:0] IX_CNT = IDX_W'(6'h2B);
  localparam logic [IDX_W-1:0] IX_MS  = IDX_W'(6'h2C);
  localparam logic [IDX_W-1:0] IX_TS  = IDX_W'(6'h2D);

  localparam int B_SRST = 0, B_TXEN = 2;
  localparam int B_RRDY = 9, B_TRDY = 13;
  localparam int B_RDR = 0, B_BRCD = 2, B_TXDC = 3, B_TXFE = 14;
  localparam int B_RXE = 5, B_CRDY = 15;
  localparam int B_TXEI = 6;

  localparam logic [REG_W-1:0] RB_RST  = REG_W'(16'h4000);
  localparam logic [REG_W-1:0] BRK_W   = REG_W'(16'h5800);
  localparam logic [REG_W-1:0] S1_RST  = REG_W'(16'h6040);
  localparam logic [REG_W-1:0] S2_RST  = REG_W'(16'h4028);
  localparam logic [REG_W-1:0] TS_RST  = REG_W'(16'h0060);
  localparam logic [REG_W-1:0] C3_RST  = REG_W'(16'h0700);
  localparam logic [REG_W-1:0] CNT_RST = REG_W'(16'h0004);
  localparam logic [REG_W-1:0] S1_W1C  = REG_W'(16'h9DB0);
  localparam logic [REG_W-1:0] S2_W1C  = REG_W'(16'hBDD6);
  localparam logic [REG_W-1:0] SRST_M  = REG_W'(1) << B_SRST;

  logic [REG_W-1:0] rb_q, c1_q, c2_q, c3_q, c4_q, fc_q, s1_q, s2_q, ts_q, bm_q, bc_q, ms_q;
  logic [REG_W-1:0] rb_n, c1_n, c2_n, c3_n, c4_n, fc_n, s1_n, s2_n, ts_n, bm_n, bc_n, ms_n;
  logic             txv_q, txv_n;
  logic [CHAR_W-1:0] txd_q, txd_n;

  wire [REG_W-1:0] wv    = wdata[REG_W-1:0];
  wire             srst  = wr_en && reg_idx == IX_C2 && !wdata[B_SRST];
  wire             taken = rd_en && reg_idx == IX_RXD && !ts_q[B_RXE];

  always_comb begin
    rb_n = rb_q; c1_n = c1_q; c2_n = c2_q; c3_n = c3_q; c4_n = c4_q; fc_n = fc_q;
    s1_n = s1_q; s2_n = s2_q; ts_n = ts_q; bm_n = bm_q; bc_n = bc_q; ms_n = ms_q;
    txv_n = 1'b0;
    txd_n = txd_q;
    if (txv_q) begin
      s1_n[B_TRDY] = 1'b1;
      s2_n[B_TXDC] = 1'b1;
    end
    if (wr_en) begin
      case (reg_idx)
        IX_TXD: if (c2_q[B_TXEN]) begin
          txv_n = 1'b1;
          txd_n = wdata[CHAR_W-1:0];
          s1_n[B_TRDY] = 1'b0;
          s2_n[B_TXDC] = 1'b0;
        end
        IX_C1:  c1_n = wv;
        IX_C2:  c2_n = wv | SRST_M;
        IX_C3:  c3_n = wv;
        IX_C4:  c4_n = wv;
        IX_FC:  fc_n = wv;
        IX_S1:  s1_n = s1_n & ~(wv & S1_W1C);
        IX_S2:  s2_n = s2_n & ~(wv & S2_W1C);
        IX_INC: bc_n = wv;
        IX_MOD: bm_n = wv;
        IX_MS:  ms_n = wv;
        default: ;
      endcase
    end
    if (taken) begin
      s1_n[B_RRDY] = 1'b0;
      s2_n[B_RDR]  = 1'b0;
      ts_n[B_RXE]  = 1'b1;
    end
    if (rx_break || (rx_valid && !s1_q[B_RRDY])) begin
      rb_n = rx_break ? BRK_W : REG_W'(rx_data);
      s1_n[B_RRDY] = 1'b1;
      s2_n[B_RDR]  = 1'b1;
      ts_n[B_RXE]  = 1'b0;
      if (rx_break) s2_n[B_BRCD] = 1'b1;
    end
    if (srst) begin
      rb_n = RB_RST; s1_n = S1_RST; s2_n = S2_RST; ts_n = TS_RST;
      c1_n = '0; c3_n = C3_RST; bm_n = '0; bc_n = CNT_RST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q <= RB_RST; s1_q <= S1_RST; s2_q <= S2_RST; ts_q <= TS_RST;
      c1_q <= '0; c2_q <= SRST_M; c3_q <= C3_RST; c4_q <= '0;
      fc_q <= '0; bm_q <= '0; bc_q <= CNT_RST; ms_q <= '0;
      txv_q <= 1'b0; txd_q <= '0;
    end else begin
      rb_q <= rb_n; s1_q <= s1_n; s2_q <= s2_n; ts_q <= ts_n;
      c1_q <= c1_n; c2_q <= c2_n; c3_q <= c3_n; c4_q <= c4_n;
      fc_q <= fc_n; bm_q <= bm_n; bc_q <= bc_n; ms_q <= ms_n;
      txv_q <= txv_n; txd_q <= txd_n;
    end
  end

  always_comb begin
    case (reg_idx)
      IX_RXD: rdata = BUS_W'(rb_q | (ts_q[B_RXE] ? '0 : (REG_W'(1) << B_CRDY)));
      IX_C1:  rdata = BUS_W'(c1_q);
      IX_C2:  rdata = BUS_W'(c2_q);
      IX_C3:  rdata = BUS_W'(c3_q);
      IX_C4:  rdata = BUS_W'(c4_q);
      IX_FC:  rdata = BUS_W'(fc_q);
      IX_S1:  rdata = BUS_W'(s1_q);
      IX_S2:  rdata = BUS_W'(s2_q);
      IX_MOD: rdata = BUS_W'(bm_q);
      IX_CNT: rdata = BUS_W'(bc_q);
      IX_MS:  rdata = BUS_W'(ms_q);
      IX_TS:  rdata = BUS_W'(ts_q);
      default: rdata = '0;
    endcase
  end

  assign rx_ready = !s1_q[B_RRDY];
  assign tx_valid = txv_q;
  assign tx_data  = txd_q;
  assign irq = (s1_q[B_TRDY] && c1_q[B_TRDY]) || (s1_q[B_RRDY] && c1_q[B_RRDY]) ||
               (s2_q[B_TXFE] && c1_q[B_TXEI]) || (s2_q[B_TXDC] && c4_q[B_TXDC]) ||
               (s2_q[B_RDR] && c4_q[B_RDR]);
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
  parameter int IDX_W  = 6,
  parameter int BUS_W  = 32,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  reg_idx,
  input logic              wr_en,
  input logic              rd_en,
  input logic [BUS_W-1:0]  wdata,
  input logic              rx_valid,
  input logic              rx_break,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [CHAR_W-1:0] tx_data,
  input logic              txen
);
  wire sr  = wr_en && reg_idx == IDX_W'(6'h21) && !wdata[0];
  wire txw = wr_en && reg_idx == IDX_W'(6'h10);
  wire rdd = rd_en && reg_idx == IDX_W'(6'h00);

  a_r10_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (txw && txen) |=> (tx_valid && tx_data == $past(wdata[CHAR_W-1:0])));
  a_r10_tx_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (txw && !txen) |=> !tx_valid);
  a_r5_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready && !rx_break && !rdd && !sr) |=> !rx_ready);
  a_r6_break_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_break && !sr) |=> !rx_ready);
  a_r4_consume: assert property (@(posedge clk) disable iff (!rst_n)
    (rdd && !rx_break && !(rx_valid && rx_ready)) |=> rx_ready);
  a_r7_srst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IDX_W'(6'h21)) |=> rx_ready || !sr);
  a_r7_srst_empties: assert property (@(posedge clk) disable iff (!rst_n)
    sr |=> rx_ready);
endmodule

bind uart_regfile uart_regfile_chk #(.IDX_W(IDX_W), .BUS_W(BUS_W), .CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rx_valid(rx_valid), .rx_break(rx_break), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_data(tx_data), .txen(c2_q[2])
);

// File: tb/uart_regfile_tb.sv
`timescale 1ns/1ps
module uart_regfile_tb;
  logic clk = 0, rst_n = 0;
  logic [5:0] reg_idx = 0;
  logic wr_en = 0, rd_en = 0, rx_valid = 0, rx_break = 0;
  logic [31:0] wdata = 0;
  logic [7:0] rx_data = 0;
  logic [31:0] rdata;
  logic rx_ready, tx_valid, irq;
  logic [7:0] tx_data;

  uart_regfile u_dut (.clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference: one integer per register word index
  int m [0:63];
  int m_txv, m_txd;
  logic [31:0] s_rdata;
  logic s_irq, s_rdy, s_txv;
  logic [7:0] s_txd;

  function automatic void m_soft();
    m[0] = 'h4000; m['h25] = 'h6040; m['h26] = 'h4028; m['h2D] = 'h60;
    m['h20] = 0; m['h22] = 'h700; m['h2A] = 0; m['h2B] = 4;
  endfunction

  function automatic void m_hard();
    for (int i = 0; i < 64; i++) m[i] = 0;
    m_soft();
    m['h21] = 1; m_txv = 0; m_txd = 0;
  endfunction

  function automatic int m_read(int idx);
    if (idx == 0) return m[0] | (((m['h2D] >> 5) & 1) != 0 ? 0 : 'h8000);
    if (idx inside {'h20, 'h21, 'h22, 'h23, 'h24, 'h25, 'h26, 'h2A, 'h2B, 'h2C, 'h2D}) return m[idx];
    return 0;
  endfunction

  function automatic bit m_irq();
    int a = m['h25] & m['h20] & 'h2200;
    return a != 0 || (m['h20][6] && m['h26][14]) || (m['h26][3] && m['h23][3]) || (m['h26][0] && m['h23][0]);
  endfunction

  function automatic void m_step(int idx, bit we, bit re, int wd, bit rv, int rc, bit rb);
    bit was_full = m['h25][9];
    bit was_empty = m['h2D][5];
    bit txen = m['h21][2];
    int v = wd & 'hFFFF;
    if (m_txv != 0) begin m['h25] |= 'h2000; m['h26] |= 'h8; end
    m_txv = 0;
    if (we) begin
      if (idx == 'h10) begin
        if (txen) begin m_txv = 1; m_txd = wd & 'hFF; m['h25] &= ~'h2000; m['h26] &= ~'h8; end
      end else if (idx == 'h21) m['h21] = v | 1;
      else if (idx == 'h25) m['h25] &= ~(v & 'h9DB0);
      else if (idx == 'h26) m['h26] &= ~(v & 'hBDD6);
      else if (idx == 'h29) m['h2B] = v;
      else if (idx inside {'h20, 'h22, 'h23, 'h24, 'h2A, 'h2C}) m[idx] = v;
    end
    if (re && idx == 0 && !was_empty) begin
      m['h25] &= ~'h200; m['h26] &= ~1; m['h2D] |= 'h20;
    end
    if (rb) begin
      m[0] = 'h5800; m['h25] |= 'h200; m['h26] |= 'h5; m['h2D] &= ~'h20;
    end else if (rv && !was_full) begin
      m[0] = rc & 'hFF; m['h25] |= 'h200; m['h26] |= 1; m['h2D] &= ~'h20;
    end
    if (we && idx == 'h21 && !wd[0]) m_soft();
  endfunction

  task automatic check(string req, string what, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic cyc(int idx, bit we, bit re, int wd, bit rv, int rc, bit rb);
    @(negedge clk);
    reg_idx = idx[5:0]; wr_en = we; rd_en = re; wdata = wd; rx_valid = rv; rx_data = rc[7:0]; rx_break = rb;
    #1;
    s_rdata = rdata; s_irq = irq; s_rdy = rx_ready; s_txv = tx_valid; s_txd = tx_data;
    check(cur_req, "rdata", rdata, m_read(idx));
    check(cur_req, "irq", irq, m_irq());
    check(cur_req, "rx_ready", rx_ready, !m['h25][9]);
    check(cur_req, "tx_valid", tx_valid, m_txv);
    if (m_txv != 0) check(cur_req, "tx_data", tx_data, m_txd);
    m_step(idx, we, re, wd, rv, rc, rb);
  endtask

  task automatic idle();               cyc(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(int idx, int d);   cyc(idx, 1, 0, d, 0, 0, 0); endtask
  task automatic rx(int c);            cyc(0, 0, 0, 0, 1, c, 0); endtask
  task automatic rd(int idx, int exp, string req);
    cyc(idx, 0, 1, 0, 0, 0, 0);
    check(req, $sformatf("read idx 0x%0h", idx), s_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_hard();
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    rd('h00, 'h4000, "R1"); rd('h20, 0, "R1"); rd('h21, 1, "R1"); rd('h22, 'h700, "R1");
    rd('h23, 0, "R1"); rd('h24, 0, "R1"); rd('h25, 'h6040, "R1"); rd('h26, 'h4028, "R1");
    rd('h2A, 0, "R1"); rd('h2B, 4, "R1"); rd('h2C, 0, "R1"); rd('h2D, 'h60, "R1");
    check("R1", "irq", s_irq, 0); check("R1", "rx_ready", s_rdy, 1);

    cur_req = "R2";
    wr('h22, 'hABCD1234); rd('h22, 'h1234, "R2");
    wr('h29, 'h55550042); rd('h2B, 'h42, "R2"); rd('h29, 0, "R2");

    cur_req = "R3";
    rd('h30, 0, "R3");
    wr('h2D, 'hFFFF); rd('h2D, 'h60, "R3");
    wr('h11, 'hFFFF); rd('h20, 0, "R3"); rd('h25, 'h6040, "R3");

    cur_req = "R10";
    wr('h10, 'h55); idle(); check("R10", "tx_valid disabled", s_txv, 0);
    wr('h21, 'h5); rd('h21, 5, "R10");
    wr('h10, 'h1A5);
    rd('h25, 'h4040, "R10"); check("R10", "tx_valid", s_txv, 1); check("R10", "tx_data", s_txd, 'hA5);
    rd('h25, 'h6040, "R10"); check("R10", "tx_valid end", s_txv, 0);
    wr('h10, 'h3C); rd('h26, 'h4020, "R10");

    cur_req = "R5";
    rx('h3C); idle(); check("R5", "rx_ready full", s_rdy, 0);
    rx('h77);
    rd('h00, 'h803C, "R4"); rd('h00, 'h003C, "R4"); rd('h25, 'h6040, "R4"); rd('h2D, 'h60, "R4");

    cur_req = "R6";
    rx('h11); cyc(0, 0, 0, 0, 1, 'h22, 1);
    rd('h26, 'h402D, "R6"); rd('h00, 'hD800, "R6");
    cur_req = "R8";
    wr('h26, 'hFFFF); rd('h26, 'h4028, "R8");
    wr('h25, 'hFFFF); rd('h25, 'h6040, "R8");

    cur_req = "R9";
    wr('h20, 'h2000); idle(); check("R9", "irq trdy", s_irq, 1);
    wr('h10, 'h41); idle(); check("R9", "irq tx pulse", s_irq, 0);
    idle(); check("R9", "irq restored", s_irq, 1);
    wr('h20, 0); idle(); check("R9", "irq off", s_irq, 0);
    wr('h20, 'h40); idle(); check("R9", "irq txfe", s_irq, 1);
    wr('h20, 0); wr('h23, 'h8); idle(); check("R9", "irq txdc", s_irq, 1);
    wr('h23, 'h1); idle(); check("R9", "irq rdr idle", s_irq, 0);
    rx('h5A); idle(); check("R9", "irq rdr", s_irq, 1);
    rd('h00, 'h805A, "R9"); idle(); check("R9", "irq cleared", s_irq, 0);
    wr('h23, 0); wr('h20, 'h200); rx('h6B); idle(); check("R9", "irq rrdy", s_irq, 1);

    cur_req = "R11";
    cyc(0, 0, 1, 0, 0, 0, 1);
    check("R11", "read before break", s_rdata, 'h806B);
    idle(); check("R11", "break kept", s_rdy, 0);
    rd('h00, 'hD800, "R11");
    cyc('h21, 1, 0, 'h4, 1, 'h99, 0);
    idle(); check("R11", "srst beats rx", s_rdy, 1);
    rd('h00, 'h4000, "R11");

    cur_req = "R7";
    wr('h23, 'h9); wr('h24, 'h0801); wr('h2C, 'h1234); wr('h22, 1); wr('h2A, 7); wr('h20, 'h40);
    rx('h12);
    wr('h21, 'h6);
    rd('h21, 7, "R7"); rd('h23, 9, "R7"); rd('h24, 'h801, "R7"); rd('h2C, 'h1234, "R7");
    rd('h22, 'h700, "R7"); rd('h2A, 0, "R7"); rd('h2B, 4, "R7"); rd('h20, 0, "R7");
    rd('h25, 'h6040, "R7"); rd('h00, 'h4000, "R7");

    cur_req = "R5";
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 16;
      int idxs [14] = '{'h00, 'h10, 'h20, 'h21, 'h22, 'h23, 'h24, 'h25, 'h26, 'h29, 'h2A, 'h2B, 'h2C, 'h2D};
      int ix = idxs[$urandom % 14];
      int d = $urandom;
      if (ix == 'h21 && ($urandom % 4) != 0) d = d | 1;
      cyc(ix, r < 5, r >= 5 && r < 10, d, r[0], $urandom, r == 15);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule